// File: doc/BRIEF.md
# Indexed Event-to-Host Interrupt Router

This block gathers 64 system event lines and turns them into 10 host interrupt lines. The routing has two stages. Each event is steered to one of 10 channels, and each channel is then steered to one of 10 hosts. An event's pending status is captured on a rising edge of its input line. It stays captured until software clears it.

Software programs the block through a small word-addressed register port. Enabling or disabling an event or a host, setting a status and clearing a status are all done by writing the index number to a dedicated address. No bitmask is used for these operations. A separate 6-bit processor output port lets firmware inject a one-shot event into the range of events 16 to 31. Hosts 2 to 9 are also driven onto an 8-bit external event-out bus.

Top module: `irq_router`

## Requirements
- R1: After reset the following all read zero:
  - every host output and every event-out line;
  - the raw status words (0x30, 0x31) and the enabled status words (0x32, 0x33);
  - every map word, which means every event routes to channel 0 and every channel routes to host 0.
- R2: A 0-to-1 change on `evt_in[e]` sets raw status bit e on the next clock edge. A line that stays high does not set the bit again after it has been cleared.
- R3: Writing index e to address 0x06 clears raw status bit e. A written value of 64 or more at 0x06, or at any other index address, changes nothing.
- R4: Writing index e to address 0x01 enables event e, and writing it to address 0x02 disables it. The enabled status words 0x32 and 0x33 read raw status AND event enable, with events 0 to 31 in word 0x32 and events 32 to 63 in word 0x33.
- R5: Event map words start at 0x10, four 8-bit fields per word. Event e sits in word 0x10 + e/4, bits 8·(e%4)+7 down to 8·(e%4). An enabled pending event drives the channel named in its field. A field value of 10 or more drives no channel.
- R6: Host map words start at 0x20 and use the same field layout, with channel c in word 0x20 + c/4. Writing index h to address 0x03 enables host h, and writing it to 0x04 disables host h. Host output h is the OR of every active channel mapped to h, forced low while host h is disabled.
- R7: Bit 0 of address 0x00 is the global enable. While it is 0, every host output is low.
- R8: A `sw_we` cycle with `sw_wdata[5]` = 1 and an index n (0 to 15) in `sw_wdata[4:0]` sets raw status of event 16+n on that clock edge. A write with bit 5 clear raises no event.
- R9: `evt_out[i]` follows `host_irq[i+2]` for i = 0 to 7.
- R10: Writing index e to address 0x05 sets raw status bit e.
- R11: When a set source and a clear of the same event land on the same edge, the set wins and the bit ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 64 | System event lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sw_we | input | 1 | Processor output-register write strobe |
| sw_wdata | input | 6 | Bit 5 fire, bits 4:0 software event index |
| host_irq | output | 10 | Host interrupt outputs |
| evt_out | output | 8 | External event-out lines (hosts 2 to 9) |

## Verification
The outputs are combinational from the registered status, enables and maps. A wrong status bit, enable bit or map field therefore shows up at the first sampling point after the edge that wrote it. It appears as a wrong `host_irq` or `evt_out` line, or as a wrong bit in the raw or enabled status words. Edge detection is probed by clearing an event while its line is still held high. Set-versus-clear priority is probed by landing a software pulse and a clear of the same event on one edge.

// File: rtl/ir_pkg.sv
package ir_pkg;
    localparam int NUM_EVT    = 64;
    localparam int NUM_CH     = 10;
    localparam int NUM_HOST   = 10;
    localparam int FIELD_W    = 8;
    localparam int FLD_PER_W  = 4;
    localparam int EVT_IW     = $clog2(NUM_EVT);
    localparam int HOST_IW    = $clog2(NUM_HOST);
    localparam int EVT_WORDS  = NUM_EVT / FLD_PER_W;
    localparam int CH_WORDS   = (NUM_CH + FLD_PER_W - 1) / FLD_PER_W;
    localparam int STAT_WORDS = NUM_EVT / 32;
    localparam int SW_BASE    = 16;
    localparam int SW_NUM     = 16;
    localparam int SW_W       = 6;
    localparam int EXT_FIRST  = 2;
    localparam int EXT_W      = 8;

    localparam logic [7:0] A_GLOBAL   = 8'h00;
    localparam logic [7:0] A_EVT_EN   = 8'h01;
    localparam logic [7:0] A_EVT_DIS  = 8'h02;
    localparam logic [7:0] A_HOST_EN  = 8'h03;
    localparam logic [7:0] A_HOST_DIS = 8'h04;
    localparam logic [7:0] A_STAT_SET = 8'h05;
    localparam logic [7:0] A_STAT_CLR = 8'h06;
    localparam logic [7:0] A_EVT_MAP  = 8'h10;
    localparam logic [7:0] A_HOST_MAP = 8'h20;
    localparam logic [7:0] A_RAW      = 8'h30;
    localparam logic [7:0] A_PEND     = 8'h32;

    typedef struct packed {
        logic                               gbl;
        logic [NUM_HOST-1:0]                host_en;
        logic [NUM_EVT-1:0][FIELD_W-1:0]    evt_map;
        logic [NUM_CH-1:0][FIELD_W-1:0]     host_map;
    } cfg_t;

    typedef struct packed {
        logic [NUM_EVT-1:0] prev;
        logic [NUM_EVT-1:0] stat;
        logic [NUM_EVT-1:0] en;
    } evt_state_t;
endpackage

// File: rtl/ir_config.sv
module ir_config
    import ir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [7:0]         addr,
    input  logic [31:0]        wdata,
    output cfg_t               cfg,
    output logic [NUM_EVT-1:0] en_set,
    output logic [NUM_EVT-1:0] en_clr,
    output logic [NUM_EVT-1:0] st_set,
    output logic [NUM_EVT-1:0] st_clr
);
    cfg_t cfg_d, cfg_q;
    logic evt_ok, host_ok;

    assign evt_ok  = wdata < 32'(NUM_EVT);
    assign host_ok = wdata < 32'(NUM_HOST);

    always_comb begin
        cfg_d  = cfg_q;
        en_set = '0;
        en_clr = '0;
        st_set = '0;
        st_clr = '0;
        if (we) begin
            if (addr == A_GLOBAL) cfg_d.gbl = wdata[0];
            if (addr == A_HOST_EN  && host_ok) cfg_d.host_en[wdata[HOST_IW-1:0]] = 1'b1;
            if (addr == A_HOST_DIS && host_ok) cfg_d.host_en[wdata[HOST_IW-1:0]] = 1'b0;
            if (addr == A_EVT_EN   && evt_ok) en_set[wdata[EVT_IW-1:0]] = 1'b1;
            if (addr == A_EVT_DIS  && evt_ok) en_clr[wdata[EVT_IW-1:0]] = 1'b1;
            if (addr == A_STAT_SET && evt_ok) st_set[wdata[EVT_IW-1:0]] = 1'b1;
            if (addr == A_STAT_CLR && evt_ok) st_clr[wdata[EVT_IW-1:0]] = 1'b1;
            for (int w = 0; w < EVT_WORDS; w++) begin
                if (addr == A_EVT_MAP + 8'(w)) begin
                    for (int k = 0; k < FLD_PER_W; k++)
                        cfg_d.evt_map[w*FLD_PER_W+k] = wdata[k*FIELD_W +: FIELD_W];
                end
            end
            for (int w = 0; w < CH_WORDS; w++) begin
                if (addr == A_HOST_MAP + 8'(w)) begin
                    for (int k = 0; k < FLD_PER_W; k++)
                        if (w*FLD_PER_W + k < NUM_CH)
                            cfg_d.host_map[w*FLD_PER_W+k] = wdata[k*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/ir_swgen.sv
module ir_swgen
    import ir_pkg::*;
(
    input  logic               sw_we,
    input  logic [SW_W-1:0]    sw_wdata,
    output logic [NUM_EVT-1:0] sw_vec
);
    always_comb begin
        sw_vec = '0;
        if (sw_we && sw_wdata[SW_W-1] && (sw_wdata[SW_W-2:0] < (SW_W-1)'(SW_NUM)))
            sw_vec[EVT_IW'(SW_BASE) + EVT_IW'(sw_wdata[SW_W-2:0])] = 1'b1;
    end
endmodule

// File: rtl/ir_event_bank.sv
module ir_event_bank
    import ir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [NUM_EVT-1:0] set_vec,
    input  logic [NUM_EVT-1:0] clr_vec,
    input  logic [NUM_EVT-1:0] en_set,
    input  logic [NUM_EVT-1:0] en_clr,
    output logic [NUM_EVT-1:0] raw_stat,
    output logic [NUM_EVT-1:0] evt_en
);
    evt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt_in;
        st_d.en   = (st_q.en & ~en_clr) | en_set;
        // set sources take priority over a clear landing on the same edge
        st_d.stat = (st_q.stat & ~clr_vec) | (evt_in & ~st_q.prev) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_stat = st_q.stat;
    assign evt_en   = st_q.en;
endmodule

// File: rtl/ir_route.sv
module ir_route
    import ir_pkg::*;
(
    input  logic                            gbl,
    input  logic [NUM_HOST-1:0]             host_en,
    input  logic [NUM_EVT-1:0]              pend,
    input  logic [NUM_EVT-1:0][FIELD_W-1:0] evt_map,
    input  logic [NUM_CH-1:0][FIELD_W-1:0]  host_map,
    output logic [NUM_HOST-1:0]             host_irq
);
    logic [NUM_CH-1:0] chan_act;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int e = 0; e < NUM_EVT; e++)
                if (evt_map[e] == FIELD_W'(c)) hit = hit | pend[e];
        end
        assign chan_act[c] = hit;
    end

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int c = 0; c < NUM_CH; c++)
                if (host_map[c] == FIELD_W'(h)) hit = hit | chan_act[c];
        end
        assign host_irq[h] = hit & host_en[h] & gbl;
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import ir_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                sw_we,
    input  logic [SW_W-1:0]     sw_wdata,
    output logic [NUM_HOST-1:0] host_irq,
    output logic [EXT_W-1:0]    evt_out
);
    cfg_t               cfg;
    logic [NUM_EVT-1:0] en_set, en_clr, st_set, st_clr, sw_vec;
    logic [NUM_EVT-1:0] raw_stat, evt_en, pend;
    logic               gbl;
    logic [NUM_HOST-1:0] host_en;

    ir_config u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cfg(cfg), .en_set(en_set), .en_clr(en_clr), .st_set(st_set), .st_clr(st_clr)
    );

    ir_swgen u_sw (.sw_we(sw_we), .sw_wdata(sw_wdata), .sw_vec(sw_vec));

    ir_event_bank u_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .set_vec(st_set | sw_vec), .clr_vec(st_clr),
        .en_set(en_set), .en_clr(en_clr),
        .raw_stat(raw_stat), .evt_en(evt_en)
    );

    assign pend    = raw_stat & evt_en;
    assign gbl     = cfg.gbl;
    assign host_en = cfg.host_en;

    ir_route u_route (
        .gbl(gbl), .host_en(host_en), .pend(pend),
        .evt_map(cfg.evt_map), .host_map(cfg.host_map), .host_irq(host_irq)
    );

    assign evt_out = host_irq[EXT_FIRST +: EXT_W];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_GLOBAL) reg_rdata[0] = gbl;
        for (int w = 0; w < EVT_WORDS; w++)
            if (reg_addr == A_EVT_MAP + 8'(w))
                for (int k = 0; k < FLD_PER_W; k++)
                    reg_rdata[k*FIELD_W +: FIELD_W] = cfg.evt_map[w*FLD_PER_W+k];
        for (int w = 0; w < CH_WORDS; w++)
            if (reg_addr == A_HOST_MAP + 8'(w))
                for (int k = 0; k < FLD_PER_W; k++)
                    if (w*FLD_PER_W + k < NUM_CH)
                        reg_rdata[k*FIELD_W +: FIELD_W] = cfg.host_map[w*FLD_PER_W+k];
        for (int w = 0; w < STAT_WORDS; w++) begin
            if (reg_addr == A_RAW  + 8'(w)) reg_rdata = raw_stat[w*32 +: 32];
            if (reg_addr == A_PEND + 8'(w)) reg_rdata = pend[w*32 +: 32];
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import ir_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_EVT-1:0]  evt_in,
    input logic                sw_we,
    input logic [SW_W-1:0]     sw_wdata,
    input logic [NUM_HOST-1:0] host_irq,
    input logic [NUM_EVT-1:0]  raw_stat,
    input logic [NUM_EVT-1:0]  pend,
    input logic [NUM_HOST-1:0] host_en,
    input logic                gbl
);
    logic [NUM_EVT-1:0] last_in, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_in <= '0;
        else        last_in <= evt_in;
    end
    assign rise = evt_in & ~last_in;

    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((raw_stat & $past(rise)) == $past(rise)));

    // R8
    sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_wdata[5] && !sw_wdata[4]) |=> raw_stat[SW_BASE + int'($past(sw_wdata[3:0]))]);

    // R7
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gbl) |-> (host_irq == '0));

    // R6
    host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_irq & ~host_en) == '0));

    // R4
    needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq != '0) |-> (pend != '0));
endmodule

bind irq_router irq_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .host_irq(host_irq), .raw_stat(raw_stat), .pend(pend), .host_en(host_en), .gbl(gbl)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt_in = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sw_we = 1'b0;
    logic [5:0]  sw_wdata = '0;
    logic [9:0]  host_irq;
    logic [7:0]  evt_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .host_irq(host_irq), .evt_out(evt_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic swr(input logic [5:0] v);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic outs(input logic [9:0] h, input string tag);
        #1;
        chk({tag, " host"}, 32'(host_irq), 32'(h));
        chk({tag, " evt_out R9"}, 32'(evt_out), 32'(h[9:2]));
    endtask

    task automatic t_reset;
        outs(10'h000, "R1 reset");
        rd(8'h30, 32'h0, "R1 raw lo");
        rd(8'h31, 32'h0, "R1 raw hi");
        rd(8'h33, 32'h0, "R1 pend hi");
        rd(8'h14, 32'h0, "R1 evt map");
        rd(8'h20, 32'h0, "R1 host map");
    endtask

    task automatic t_route;
        wr(8'h14, 32'h0200_0000);   // event 19 -> channel 2
        wr(8'h20, 32'h0002_0000);   // channel 2 -> host 2
        wr(8'h03, 32'd2);
        wr(8'h01, 32'd19);
        wr(8'h00, 32'd1);
        rd(8'h14, 32'h0200_0000, "R5 map readback");
        swr(6'h23);
        outs(10'h004, "R8 R5 R6 sw event 19");
        rd(8'h30, 32'h0008_0000, "R8 raw lo");
        rd(8'h32, 32'h0008_0000, "R4 pend lo");
        wr(8'h06, 32'd64);
        rd(8'h30, 32'h0008_0000, "R3 clear out of range");
        wr(8'h06, 32'd19);
        outs(10'h000, "R3 cleared");
        rd(8'h30, 32'h0, "R3 raw after clear");
    endtask

    task automatic t_global;
        wr(8'h05, 32'd19);
        outs(10'h004, "R10 set by index");
        wr(8'h00, 32'd0);
        outs(10'h000, "R7 global off");
        wr(8'h00, 32'd1);
        outs(10'h004, "R7 global on");
        wr(8'h06, 32'd19);
    endtask

    task automatic t_raw;
        wr(8'h1A, 32'h0000_0009);   // event 40 -> channel 9
        wr(8'h22, 32'h0000_0900);   // channel 9 -> host 9
        wr(8'h03, 32'd9);
        wr(8'h01, 32'd40);
        @(negedge clk);
        evt_in[40] = 1'b1;
        @(negedge clk);
        outs(10'h200, "R2 R9 raw edge");
        wr(8'h06, 32'd40);
        rd(8'h31, 32'h0, "R2 held high no relatch");
        @(negedge clk);
        evt_in[40] = 1'b0;
        @(negedge clk);
        evt_in[40] = 1'b1;
        @(negedge clk);
        rd(8'h31, 32'h0000_0100, "R2 second edge");
        evt_in[40] = 1'b0;
    endtask

    task automatic t_disable;
        wr(8'h02, 32'd40);
        outs(10'h000, "R4 event disabled");
        rd(8'h33, 32'h0, "R4 pend hi");
        rd(8'h31, 32'h0000_0100, "R4 raw kept");
        wr(8'h01, 32'd40);
        outs(10'h200, "R4 re-enabled");
        wr(8'h04, 32'd9);
        outs(10'h000, "R6 host disabled");
        wr(8'h03, 32'd12);
        outs(10'h000, "R6 host index out of range");
        wr(8'h06, 32'd40);
    endtask

    task automatic t_nop;
        swr(6'h03);
        rd(8'h30, 32'h0, "R8 bit5 clear no event");
        swr(6'h30);
        rd(8'h31, 32'h0, "R8 index 16 ignored");
        swr(6'h2F);
        rd(8'h30, 32'h8000_0000, "R8 event 31");
        wr(8'h06, 32'd31);
    endtask

    task automatic t_simul;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h06; reg_wdata = 32'd17;
        sw_we = 1'b1; sw_wdata = 6'h21;
        @(negedge clk);
        reg_we = 1'b0; sw_we = 1'b0;
        rd(8'h30, 32'h0002_0000, "R11 set wins over clear");
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_route();
        t_global();
        t_raw();
        t_disable();
        t_nop();
        t_simul();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule